// File: doc/BRIEF.md
# Stuff Code Sync Maintenance Checker

Once a demultiplexer has acquired frame sync, this block confirms that the sync is still valid. At each end-of-scan strobe it takes in the serial data bit, which at that moment is bit 0 of the current data word. It compares that bit with the matching bit of three serial stuff command code streams: positive stuff, negative stuff and no stuff.

A mismatch is counted in one of three saturating error counters. Only the counter picked by the one-hot select at the last sync-acquired pulse can advance. Counting is limited to a window of data words in each minor frame. The counters are cleared when sync is acquired, and in maintenance mode they are also cleared at a fixed word near the end of every frame. The captured bit is also presented as an overhead data output. Deciding when sync has been lost is left to the logic that reads the counters.

Top module: `stuff_sync_checker`

## Requirements
- R1: While `rst_n` is low at a clock edge, all three counters and `ovh_data` are set to 0, and the block is disarmed.
- R2: At a clock edge where `eos` is high, `ovh_data` takes the value of `ser_bit`. At every other edge it holds its value.
- R3: Before the first `sync_pulse` after reset, no counter changes, whatever mismatches occur.
- R4: At an edge where `sync_pulse` is high, all three counters become 0 and the select in `sel_oh` is stored. No count happens at that edge.
- R5: After arming, an `eos` edge with `word_num` between 12 and 23 inclusive adds one to the selected counter when `ser_bit` differs from that counter's code bit. When the bits match, the counter is unchanged.
- R6: An `eos` edge with `word_num` below 12 or above 23 changes no counter, and the clear in R8 is the only exception.
- R7: A counter that has reached 15 stays at 15 on further mismatches until it is cleared.
- R8: An edge with `maint_mode`, `eos` and `word_num == 29` all high clears all three counters. With `maint_mode` low, word 29 clears nothing.
- R9: `code_bits[0]`, `code_bits[1]` and `code_bits[2]` drive `cnt_pos`, `cnt_neg` and `cnt_none` respectively, and `sel_oh` uses the same bit order. Unselected counters never advance.
- R10: A later `sync_pulse` replaces the stored select, so counting moves to the newly selected counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_bit | input | 1 | Serial data bit |
| eos | input | 1 | End-of-scan strobe, high during bit 0 of a word |
| word_num | input | 5 | Current word number within the minor frame |
| code_bits | input | 3 | Current bits of the three stuff code streams (positive, negative, none) |
| sel_oh | input | 3 | One-hot select from the acquisition stage |
| sync_pulse | input | 1 | Sync-acquired pulse |
| maint_mode | input | 1 | Maintenance mode flag |
| cnt_pos | output | 4 | Error count against the positive stuff code |
| cnt_neg | output | 4 | Error count against the negative stuff code |
| cnt_none | output | 4 | Error count against the no-stuff code |
| ovh_data | output | 1 | Overhead data: the captured bit 0 |

## Verification
The hardest state to reach is a saturated counter whose value must hold through words 24 to 31 and then fall to zero only at word 29 in maintenance mode. Random code bits rarely produce enough in-window mismatches to reach 15. The stimulus therefore has a mode that drives each code bit as the inverse of the data bit, which forces twelve mismatches per frame. Running two such frames, with maintenance mode first off and then on, separates saturation, the window edges and the maintenance clear.

// File: rtl/sc_pkg.sv
// Shared definitions for the stuff code sync maintenance checker.
// Assumes three code streams in the fixed order positive, negative, none.
package sc_pkg;
    localparam int NCODE = 3;

    typedef enum int {
        CODE_POS  = 0,
        CODE_NEG  = 1,
        CODE_NONE = 2
    } code_idx_e;
endpackage

// File: rtl/sc_capture.sv
// Data-in register: captures the serial bit on the end-of-scan strobe.
// Assumes the strobe is high exactly during bit 0 of each word.
module sc_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic eos_i,
    input  logic bit_i,
    output logic bit_q_o
);
    // Capture bit 0 of the current word, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     bit_q_o <= 1'b0;
        else if (eos_i) bit_q_o <= bit_i;
    end

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eos_i |=> $stable(bit_q_o));
    // R2
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eos_i |=> (bit_q_o == $past(bit_i)));
endmodule

// File: rtl/sc_gate.sv
// Arming, select storage, word window and clear generation.
// Produces one increment request per code stream and a common clear.
// Assumes sel_i is one-hot or zero when sync_i is high.
module sc_gate #(
    parameter int WORD_W    = 5,
    parameter int WIN_FIRST = 12,
    parameter int WIN_LAST  = 23,
    parameter int CLR_WORD  = 29
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       eos_i,
    input  logic [WORD_W-1:0]          word_i,
    input  logic                       sync_i,
    input  logic [sc_pkg::NCODE-1:0]   sel_i,
    input  logic                       maint_i,
    input  logic                       ser_i,
    input  logic [sc_pkg::NCODE-1:0]   code_i,
    output logic [sc_pkg::NCODE-1:0]   inc_o,
    output logic                       clr_o
);
    localparam int N = sc_pkg::NCODE;

    logic         armed_q;
    logic [N-1:0] sel_q;
    logic         in_win;
    logic         maint_clr;

    // Arm on the first sync pulse and remember the select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            sel_q   <= '0;
        end else if (sync_i) begin
            armed_q <= 1'b1;
            sel_q   <= sel_i;
        end
    end

    // Word window and clear decode.
    always_comb begin
        in_win    = (word_i >= WORD_W'(WIN_FIRST)) && (word_i <= WORD_W'(WIN_LAST));
        maint_clr = maint_i && eos_i && (word_i == WORD_W'(CLR_WORD));
        clr_o     = sync_i || maint_clr;
    end

    // One increment request per stream, on a mismatch.
    for (genvar k = 0; k < N; k++) begin : g_req
        assign inc_o[k] = armed_q && eos_i && in_win && !clr_o
                          && sel_q[k] && (ser_i ^ code_i[k]);
    end

    // R9
    one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inc_o));
    // R6
    window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eos_i && !in_win) |-> (inc_o == '0));
endmodule

// File: rtl/sc_err_counter.sv
// Saturating error counter with a synchronous clear that takes priority.
// Assumes at most one increment per clock.
module sc_err_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Clear, saturating increment, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_o <= '0;
        else if (clr_i)                      cnt_o <= '0;
        else if (inc_i && cnt_o != CNT_MAX)  cnt_o <= cnt_o + CNT_W'(1);
    end

    // R4
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0));
    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == CNT_MAX && !clr_i) |=> (cnt_o == CNT_MAX));
    // R5
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + CNT_W'(1)));
endmodule

// File: rtl/stuff_sync_checker.sv
// Top level: checks bit 0 of each word against three stuff code streams
// and counts mismatches for the stream chosen at sync acquisition.
// Assumes word_num, code_bits and ser_bit are valid whenever eos is high.
module stuff_sync_checker #(
    parameter int CNT_W     = 4,
    parameter int WORD_W    = 5,
    parameter int WIN_FIRST = 12,
    parameter int WIN_LAST  = 23,
    parameter int CLR_WORD  = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_bit,
    input  logic              eos,
    input  logic [WORD_W-1:0] word_num,
    input  logic [2:0]        code_bits,
    input  logic [2:0]        sel_oh,
    input  logic              sync_pulse,
    input  logic              maint_mode,
    output logic [CNT_W-1:0]  cnt_pos,
    output logic [CNT_W-1:0]  cnt_neg,
    output logic [CNT_W-1:0]  cnt_none,
    output logic              ovh_data
);
    localparam int N = sc_pkg::NCODE;

    logic [N-1:0]     inc;
    logic             clr;
    logic [CNT_W-1:0] cnt [N];

    sc_capture u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .eos_i   (eos),
        .bit_i   (ser_bit),
        .bit_q_o (ovh_data)
    );

    sc_gate #(
        .WORD_W    (WORD_W),
        .WIN_FIRST (WIN_FIRST),
        .WIN_LAST  (WIN_LAST),
        .CLR_WORD  (CLR_WORD)
    ) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .eos_i   (eos),
        .word_i  (word_num),
        .sync_i  (sync_pulse),
        .sel_i   (sel_oh),
        .maint_i (maint_mode),
        .ser_i   (ser_bit),
        .code_i  (code_bits),
        .inc_o   (inc),
        .clr_o   (clr)
    );

    for (genvar k = 0; k < N; k++) begin : g_cnt
        sc_err_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (clr),
            .inc_i (inc[k]),
            .cnt_o (cnt[k])
        );
    end

    assign cnt_pos  = cnt[sc_pkg::CODE_POS];
    assign cnt_neg  = cnt[sc_pkg::CODE_NEG];
    assign cnt_none = cnt[sc_pkg::CODE_NONE];

    // R3
    idle_before_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(u_gate.armed_q) && !sync_pulse) |-> $stable(cnt_pos) && $stable(cnt_neg) && $stable(cnt_none));
endmodule

// File: tb/sim_stuff_sync_checker.sv
module sim_stuff_sync_checker;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_bit = 1'b0;
    logic       eos = 1'b0;
    logic [4:0] word_num = '0;
    logic [2:0] code_bits = '0;
    logic [2:0] sel_oh = '0;
    logic       sync_pulse = 1'b0;
    logic       maint_mode = 1'b0;
    logic [3:0] cnt_pos, cnt_neg, cnt_none;
    logic       ovh_data;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    string cur_req = "R1";
    bit force_mm = 0;
    bit done = 0;

    // Reference model state.
    int  m_cnt [3];
    bit  m_ovh;
    bit  m_armed;
    bit [2:0] m_sel;

    stuff_sync_checker u0 (
        .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .eos(eos),
        .word_num(word_num), .code_bits(code_bits), .sel_oh(sel_oh),
        .sync_pulse(sync_pulse), .maint_mode(maint_mode),
        .cnt_pos(cnt_pos), .cnt_neg(cnt_neg), .cnt_none(cnt_none),
        .ovh_data(ovh_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference, updated at each rising edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            foreach (m_cnt[i]) m_cnt[i] = 0;
            m_ovh = 0; m_armed = 0; m_sel = 0;
        end else begin
            if (eos) m_ovh = ser_bit;
            if (sync_pulse) begin
                foreach (m_cnt[i]) m_cnt[i] = 0;
                m_armed = 1; m_sel = sel_oh;
            end else if (maint_mode && eos && word_num == 29) begin
                foreach (m_cnt[i]) m_cnt[i] = 0;
            end else if (m_armed && eos && word_num >= 12 && word_num <= 23) begin
                for (int k = 0; k < 3; k++)
                    if (m_sel[k] && ser_bit != code_bits[k] && m_cnt[k] < 15)
                        m_cnt[k]++;
            end
        end
    end

    task automatic finish_up();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic compare();
        n_chk++;
        if (cnt_pos !== 4'(m_cnt[0]) || cnt_neg !== 4'(m_cnt[1]) ||
            cnt_none !== 4'(m_cnt[2]) || ovh_data !== m_ovh) begin
            n_bad++;
            $display("FAIL %s: got pos=%0d neg=%0d none=%0d ovh=%0b expected pos=%0d neg=%0d none=%0d ovh=%0b",
                     cur_req, cnt_pos, cnt_neg, cnt_none, ovh_data,
                     m_cnt[0], m_cnt[1], m_cnt[2], m_ovh);
        end
    endtask

    // Advance one clock and compare away from the rising edge.
    task automatic step();
        @(negedge clk);
        compare();
    endtask

    task automatic randomize_data();
        ser_bit = 1'($urandom);
        code_bits = force_mm ? {3{~ser_bit}} : 3'($urandom);
    endtask

    task automatic word_slot(input int w);
        for (int i = 0; i < 2; i++) begin
            eos = 0; randomize_data(); word_num = 5'($urandom); step();
        end
        eos = 1; word_num = 5'(w); randomize_data(); step();
        eos = 0;
    endtask

    task automatic frame();
        for (int w = 0; w < 32; w++) word_slot(w);
    endtask

    task automatic acquire(input logic [2:0] s);
        sync_pulse = 1; sel_oh = s; randomize_data(); step();
        sync_pulse = 0; sel_oh = 3'($urandom);
    endtask

    task automatic expect_cnt(input string req, input int idx, input int val);
        int got;
        got = (idx == 0) ? int'(cnt_pos) : (idx == 1) ? int'(cnt_neg) : int'(cnt_none);
        n_chk++;
        if (got != val) begin
            n_bad++;
            $display("FAIL %s: counter %0d got %0d expected %0d", req, idx, got, val);
        end
    endtask

    initial begin
        void'($urandom(7));
        @(negedge clk); @(negedge clk);
        cur_req = "R1"; step(); step();
        rst_n = 1;
        cur_req = "R3"; force_mm = 1; frame(); force_mm = 0;
        expect_cnt("R3", 0, 0);
        cur_req = "R4"; acquire(3'b001);
        cur_req = "R5"; frame(); frame();
        cur_req = "R2"; for (int i = 0; i < 20; i++) word_slot(i);
        cur_req = "R7"; force_mm = 1; acquire(3'b001); frame();
        expect_cnt("R7", 0, 12);
        cur_req = "R6"; frame();
        expect_cnt("R7", 0, 15);
        expect_cnt("R9", 1, 0);
        cur_req = "R8"; maint_mode = 1; frame();
        expect_cnt("R8", 0, 0);
        maint_mode = 0; force_mm = 0;
        cur_req = "R10"; acquire(3'b100); force_mm = 1; frame(); force_mm = 0;
        expect_cnt("R10", 2, 12);
        expect_cnt("R9", 0, 0);
        cur_req = "R9"; acquire(3'b010); frame(); frame();
        expect_cnt("R9", 2, 0);
        cur_req = "R1"; rst_n = 0; step(); rst_n = 1; step();
        done = 1;
        finish_up();
    end

    initial begin
        wait (cycles >= MAX_CYCLES);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cycles, MAX_CYCLES);
            finish_up();
        end
    end
endmodule